// File: doc/BRIEF.md
# Two-Way LRU Tag Directory

This block is the tag side of a small two-way set-associative cache. It holds four sets of two ways. For each way it keeps a tag and a valid bit. For each way it also keeps an age bit: 0 means the way was used most recently, 1 means it is the older of the two. The block accepts one lookup per clock, given as a strobe and a word address. One cycle later it reports whether the lookup hit, which set the address mapped to, and which way was hit or filled.

On a miss the line is installed at once. An empty way is used first, and way 0 is used before way 1. If both ways hold valid lines, the older one is replaced. A parameter sets the line size to one word or two words. With two-word lines, the low address bit is dropped before the set and the tag are taken, so both words of an aligned pair share one entry. Two saturating counters report how many lookups were made and how many of them hit.

Top module: `lru2_dir`

## Requirements
- R1: With LINE_WORDS=1, the reported set is address mod 4 and the tag is address divided by 4. For example, addresses 0 and 4 both go to set 0, and addresses 1 and 5 both go to set 1.
- R2: With LINE_WORDS=2, the set is bits [2:1] of the address and the tag is address divided by 8. After a lookup of one word, a lookup of its partner (the same address with bit 0 flipped) hits.
- R3: rsp_valid_o is high in exactly the cycles that follow a cycle with req_valid_i high.
- R4: A lookup hits when a valid way of its set holds the same tag. rsp_way_o then gives that way (0 or 1), and the tag held in that way is left unchanged.
- R5: On a miss, an invalid way is filled. When both ways are invalid, way 0 is filled.
- R6: Every lookup makes its way the most recent in the set and makes the other valid way the older. On a miss in a set whose two ways are both valid, the older way is replaced and reported.
- R7: After reset all ways are invalid, so the first lookup to any set misses. rsp_valid_o is 0 and both counters are 0.
- R8: access_count_o is incremented for every lookup and holds at 2^CNT_W-1 once it reaches that value.
- R9: hit_count_o is incremented for every hit, holds at 2^CNT_W-1 once it reaches that value, and never exceeds access_count_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup strobe |
| req_addr_i | input | ADDR_W | Word address of the lookup |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | 1 on a hit, 0 on a miss |
| rsp_set_o | output | SET_W | Set index of the lookup |
| rsp_way_o | output | 1 | Way that was hit or filled |
| access_count_o | output | CNT_W | Saturating count of lookups |
| hit_count_o | output | CNT_W | Saturating count of hits |

## Verification
A wrong age bit does not show up right away. It becomes visible only at the next miss in that set whose two ways are both valid. At that point rsp_way_o names the wrong victim, and a later lookup of the line that was wrongly evicted misses. A tag or valid bit that is corrupted shows on the next lookup of that set as a wrong hit flag. Within about one more cycle the hit counter also drifts. For this reason the bench runs a behavioural model of the directory against every response of both line-size variants. It uses an address range small enough that replacements happen often.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int unsigned NUM_WAYS = 2;

  function automatic int unsigned line_off_bits(int unsigned words);
    return (words > 1) ? 1 : 0;
  endfunction
endpackage

// File: rtl/dir_addr_map.sv
module dir_addr_map #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned OFF_W  = 0,
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SET_W-1:0]  set_o,
  output logic [TAG_W-1:0]  tag_o
);
  generate
    if (OFF_W == 0) begin : g_word
      assign set_o = addr_i[SET_W-1:0];
      assign tag_o = addr_i[ADDR_W-1:SET_W];
    end else begin : g_pair
      logic [OFF_W-1:0] unused_off;
      assign unused_off = addr_i[OFF_W-1:0];
      assign set_o = addr_i[OFF_W +: SET_W];
      assign tag_o = addr_i[ADDR_W-1:OFF_W+SET_W];
    end
  endgenerate
endmodule

// File: rtl/dir_set.sv
module dir_set #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic             way_o
);
  logic [1:0]            vld_q;
  logic [1:0]            age_q;
  logic [1:0][TAG_W-1:0] tag_q;
  logic [1:0]            match;
  logic                  victim;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = vld_q[w] && (tag_q[w] == tag_i);
  end

  always_comb begin
    if (!vld_q[0])      victim = 1'b0;
    else if (!vld_q[1]) victim = 1'b1;
    else                victim = age_q[1];
  end

  assign hit_o = |match;
  assign way_o = hit_o ? match[1] : victim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      age_q <= '0;
      tag_q <= '0;
    end else if (acc_i) begin
      vld_q[way_o]  <= 1'b1;
      tag_q[way_o]  <= tag_i;
      age_q[way_o]  <= 1'b0;
      age_q[!way_o] <= vld_q[!way_o];
    end
  end

  a_r4_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r6_one_older: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q == 2'b11) |-> ($countones(age_q) == 1));
  a_r4_hit_keeps_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && hit_o) |=> $stable(tag_q));
endmodule

// File: rtl/dir_sat_cnt.sv
module dir_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (inc_i && ~&cnt_o)    cnt_o <= cnt_o + 1'b1;
  end

  // R8 and R9: a full count never wraps
  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));
endmodule

// File: rtl/lru2_dir.sv
module lru2_dir
  import dir_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_SETS   = 4,
  parameter int unsigned LINE_WORDS = 1,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned OFF_W = line_off_bits(LINE_WORDS),
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [SET_W-1:0]  rsp_set_o,
  output logic              rsp_way_o,
  output logic [CNT_W-1:0]  access_count_o,
  output logic [CNT_W-1:0]  hit_count_o
);
  logic [SET_W-1:0]    set_idx;
  logic [TAG_W-1:0]    tag;
  logic [NUM_SETS-1:0] set_hit;
  logic [NUM_SETS-1:0] set_way;
  logic                lk_hit;
  logic                lk_way;

  dir_addr_map #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_map (
    .addr_i (req_addr_i),
    .set_o  (set_idx),
    .tag_o  (tag)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    dir_set #(.TAG_W(TAG_W)) u_set (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (req_valid_i && (set_idx == SET_W'(s))),
      .tag_i  (tag),
      .hit_o  (set_hit[s]),
      .way_o  (set_way[s])
    );
  end

  assign lk_hit = set_hit[set_idx];
  assign lk_way = set_way[set_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_set_o   <= '0;
      rsp_way_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o <= lk_hit;
        rsp_set_o <= set_idx;
        rsp_way_o <= lk_way;
      end
    end
  end

  dir_sat_cnt #(.W(CNT_W)) u_acc_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (req_valid_i), .cnt_o (access_count_o)
  );
  dir_sat_cnt #(.W(CNT_W)) u_hit_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (req_valid_i && lk_hit), .cnt_o (hit_count_o)
  );

  a_r3_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r3_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r9_hits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_count_o <= access_count_o);
  a_r8_access_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ~&access_count_o) |=> (access_count_o == $past(access_count_o) + 1'b1));
endmodule

// File: tb/sim_lru2_dir.sv
module sim_lru2_dir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  always #2.5 clk = ~clk;

  logic       v0, h0, w0, v1, h1, w1;
  logic [1:0] s0, s1;
  logic [7:0] ac0, hc0, ac1, hc1;

  lru2_dir #(.LINE_WORDS(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(v0), .rsp_hit_o(h0), .rsp_set_o(s0), .rsp_way_o(w0),
    .access_count_o(ac0), .hit_count_o(hc0));
  lru2_dir #(.LINE_WORDS(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(v1), .rsp_hit_o(h1), .rsp_set_o(s1), .rsp_way_o(w1),
    .access_count_o(ac1), .hit_count_o(hc1));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_tag [2][4][2];
  bit m_val [2][4][2];
  bit m_age [2][4][2];
  int m_acc [2], m_hit [2];
  int e_hit [2], e_set [2], e_way [2];
  bit e_vld;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_acc[k] = 0; m_hit[k] = 0;
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++) begin
          m_val[k][s][w] = 0; m_age[k][s][w] = 0; m_tag[k][s][w] = 0;
        end
    end
    e_vld = 0;
  endtask

  task automatic model_step(int addr);
    for (int k = 0; k < 2; k++) begin
      int line, s, t, w;
      bit hit;
      line = addr >> k;
      s = line % 4;
      t = line / 4;
      hit = 0; w = 0;
      for (int i = 0; i < 2; i++)
        if (m_val[k][s][i] && m_tag[k][s][i] == t) begin hit = 1; w = i; end
      if (!hit) begin
        if (!m_val[k][s][0]) w = 0;
        else if (!m_val[k][s][1]) w = 1;
        else w = m_age[k][s][0] ? 0 : 1;
      end
      m_val[k][s][w] = 1; m_tag[k][s][w] = t; m_age[k][s][w] = 0;
      if (m_val[k][s][1-w]) m_age[k][s][1-w] = 1;
      if (m_acc[k] < 255) m_acc[k]++;
      if (hit && m_hit[k] < 255) m_hit[k]++;
      e_hit[k] = hit; e_set[k] = s; e_way[k] = w;
    end
  endtask

  task automatic compare();
    chk("R3 u0 rsp_valid", v0, e_vld);
    chk("R3 u1 rsp_valid", v1, e_vld);
    if (e_vld) begin
      chk("R4 u0 hit", h0, e_hit[0]);
      chk("R1 u0 set", s0, e_set[0]);
      chk("R6 u0 way", w0, e_way[0]);
      chk("R4 u1 hit", h1, e_hit[1]);
      chk("R2 u1 set", s1, e_set[1]);
      chk("R6 u1 way", w1, e_way[1]);
    end
    chk("R8 u0 access_count", ac0, m_acc[0]);
    chk("R8 u1 access_count", ac1, m_acc[1]);
    chk("R9 u0 hit_count", hc0, m_hit[0]);
    chk("R9 u1 hit_count", hc1, m_hit[1]);
  endtask

  task automatic do_req(int addr);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 8'(addr);
    model_step(addr);
    @(negedge clk);
    req_valid = 1'b0;
    e_vld = 1;
    compare();
  endtask

  task automatic do_idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    e_vld = 0;
    compare();
  endtask

  initial begin
    int x;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R7 reset rsp_valid", v0, 0);
    chk("R7 reset access_count", ac0, 0);
    chk("R7 reset hit_count", hc1, 0);
    rst_n = 1'b1;

    do_req(0);
    chk("R7 first lookup misses", h0, 0);
    chk("R5 empty set fills way 0", w0, 0);
    do_req(1);
    chk("R2 partner word hits", h1, 1);
    chk("R1 address 1 in set 1", s0, 1);
    do_req(4);
    chk("R5 second fill uses way 1", w0, 1);
    chk("R1 address 4 in set 0", s0, 0);
    do_req(0);
    chk("R4 hit on way 0", h0, 1);
    chk("R4 hit way", w0, 0);
    do_req(8);
    chk("R6 evicts older way 1", w0, 1);
    chk("R6 eviction is a miss", h0, 0);
    do_req(4);
    chk("R6 evicts older way 0", w0, 0);
    chk("R6 evicted line misses", h0, 0);
    do_idle();
    chk("R3 idle gives no response", v0, 0);

    x = 5;
    for (int i = 0; i < 400; i++) begin
      x = (x * 13 + 7) % 256;
      do_req((x >> 2) % 16);
      if (i % 37 == 0) do_idle();
    end
    chk("R8 access_count saturates", ac0, 255);
    for (int i = 0; i < 300; i++) do_req(0);
    chk("R9 hit_count saturates", hc0, 255);
    chk("R9 hit_count saturates u1", hc1, 255);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule